// File: doc/BRIEF.md
# Operand-Waiting Reservation Station

This block is a small pool of instruction slots placed in front of one functional unit of an out-of-order core. The issue stage writes an operation code, the reorder-buffer tag that names the result, and two source operands into a free slot. Each operand arrives either as a finished value or as the reorder-buffer tag of the instruction that will produce it. An issue is taken only when a slot is free and the issue stage also reports a free reorder-buffer entry.

Every slot watches the shared result bus. When a broadcast tag matches a pending operand, the slot copies the broadcast value and marks that operand ready. One broadcast can wake any number of slots, and an operand that is issued in the same cycle as its producer's broadcast takes the value at once. A slot whose two operands are both ready is offered to the functional unit. When several slots are ready, the oldest one goes first, where age is the distance of the slot's destination tag from the current reorder-buffer head. The slot is released when the functional unit accepts it. A flush empties the pool in one cycle.

Each slot is a three-state machine. The states are FREE (empty), WAIT (holds an instruction with at least one pending operand) and READY (both operands held). The transitions are: FREE to WAIT on an issue that leaves an operand pending; FREE to READY on an issue whose operands are all present, counting a same-cycle capture; WAIT to WAIT on a capture that leaves the other operand pending; WAIT to READY on the capture that completes the pair; READY to FREE on dispatch; and any state to FREE on flush.

Top module: `rs_pool`

## Requirements
- R1: An issue is accepted only when `iss_valid`, `rob_avail` and `iss_ready` are all high and `flush` is low. `iss_ready` is high whenever at least one slot is empty. An issue that is not accepted leaves the pool unchanged.
- R2: A source whose ready flag is 1 at issue is stored as the given value. It is later presented unchanged on `disp_a`/`disp_b`, together with `disp_op` and `disp_dst`.
- R3: A pending source captures `bus_data` in a cycle where `bus_valid` is high and `bus_tag` equals its tag. A broadcast with any other tag leaves the source pending.
- R4: `disp_valid` is high only while some slot holds two ready operands. It rises in the cycle after the edge at which the last operand was stored or captured.
- R5: A single broadcast is captured by every pending source that carries the matching tag, across all slots.
- R6: A slot is released at the edge where `disp_valid` and `fu_ready` are both high. While `fu_ready` is low, the offered instruction stays on the outputs.
- R7: Among ready slots, the slot offered is the one with the smallest age `(dst - rob_head) mod 2^TAG_W`. At most one slot is offered per cycle.
- R8: When a broadcast matches the tag of a source that is being issued in the same cycle, the stored operand is `bus_data` and counts as ready.
- R9: `flush` empties every slot at the next edge, and an issue presented in the flush cycle is discarded.
- R10: After reset, `iss_ready` is 1 and `disp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empty all slots |
| rob_head | input | TAG_W | Tag of the oldest in-flight instruction, used for age |
| rob_avail | input | 1 | A reorder-buffer entry is available for this issue |
| iss_valid | input | 1 | Issue request |
| iss_ready | output | 1 | At least one slot is empty |
| iss_op | input | OP_W | Operation code |
| iss_dst | input | TAG_W | Destination reorder-buffer tag |
| iss_a_rdy | input | 1 | Source A is a value (1) or a tag (0) |
| iss_a_val | input | DATA_W | Source A value |
| iss_a_tag | input | TAG_W | Source A producer tag |
| iss_b_rdy | input | 1 | Source B is a value (1) or a tag (0) |
| iss_b_val | input | DATA_W | Source B value |
| iss_b_tag | input | TAG_W | Source B producer tag |
| bus_valid | input | 1 | Result broadcast present |
| bus_tag | input | TAG_W | Tag of broadcast result |
| bus_data | input | DATA_W | Broadcast value |
| fu_ready | input | 1 | Functional unit accepts the offered instruction |
| disp_valid | output | 1 | An instruction is offered |
| disp_op | output | OP_W | Offered operation code |
| disp_dst | output | TAG_W | Offered destination tag |
| disp_a | output | DATA_W | Offered source A |
| disp_b | output | DATA_W | Offered source B |

## Verification
Issue and broadcast can land in the same cycle. The bench provokes this by presenting a pending source together with a broadcast of its tag, and it judges the case correct when the instruction is offered on the next cycle carrying the broadcast value. A non-matching broadcast in the same cycle must leave the instruction waiting. Flush and issue also share a cycle: the issued instruction must not appear, and a later broadcast must not revive a slot that was pending before the flush. Wake-up of two slots by one broadcast is judged by the order and contents of the two dispatches that follow.

// File: rtl/rs_pkg.sv
package rs_pkg;
    typedef enum logic [1:0] {
        SLOT_FREE  = 2'd0,
        SLOT_WAIT  = 2'd1,
        SLOT_READY = 2'd2
    } slot_state_e;
endpackage

// File: rtl/rs_slot.sv
module rs_slot
    import rs_pkg::*;
#(
    parameter int OP_W   = 4,
    parameter int TAG_W  = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              load,
    input  logic              grant,
    input  logic [OP_W-1:0]   in_op,
    input  logic [TAG_W-1:0]  in_dst,
    input  logic              in_a_rdy,
    input  logic [DATA_W-1:0] in_a_val,
    input  logic [TAG_W-1:0]  in_a_tag,
    input  logic              in_b_rdy,
    input  logic [DATA_W-1:0] in_b_val,
    input  logic [TAG_W-1:0]  in_b_tag,
    input  logic              bus_valid,
    input  logic [TAG_W-1:0]  bus_tag,
    input  logic [DATA_W-1:0] bus_data,
    output logic              out_free,
    output logic              out_ready,
    output logic [OP_W-1:0]   out_op,
    output logic [TAG_W-1:0]  out_dst,
    output logic [DATA_W-1:0] out_a,
    output logic [DATA_W-1:0] out_b
);
    slot_state_e state_q, state_d;

    logic [OP_W-1:0]   op_q, op_d;
    logic [TAG_W-1:0]  dst_q, dst_d;
    logic              a_rdy_q, a_rdy_d, b_rdy_q, b_rdy_d;
    logic [DATA_W-1:0] a_q, a_d, b_q, b_d;
    logic [TAG_W-1:0]  a_tag_q, a_tag_d, b_tag_q, b_tag_d;

    logic new_a_hit, new_b_hit, old_a_hit, old_b_hit;

    assign new_a_hit = bus_valid && !in_a_rdy && (bus_tag == in_a_tag);
    assign new_b_hit = bus_valid && !in_b_rdy && (bus_tag == in_b_tag);
    assign old_a_hit = bus_valid && !a_rdy_q  && (bus_tag == a_tag_q);
    assign old_b_hit = bus_valid && !b_rdy_q  && (bus_tag == b_tag_q);

    always_comb begin
        state_d = state_q;
        op_d    = op_q;
        dst_d   = dst_q;
        a_rdy_d = a_rdy_q;
        a_d     = a_q;
        a_tag_d = a_tag_q;
        b_rdy_d = b_rdy_q;
        b_d     = b_q;
        b_tag_d = b_tag_q;
        unique case (state_q)
            SLOT_FREE: begin
                if (load) begin
                    op_d    = in_op;
                    dst_d   = in_dst;
                    a_tag_d = in_a_tag;
                    b_tag_d = in_b_tag;
                    a_rdy_d = in_a_rdy || new_a_hit;
                    b_rdy_d = in_b_rdy || new_b_hit;
                    a_d     = in_a_rdy ? in_a_val : bus_data;
                    b_d     = in_b_rdy ? in_b_val : bus_data;
                    state_d = (a_rdy_d && b_rdy_d) ? SLOT_READY : SLOT_WAIT;
                end
            end
            SLOT_WAIT: begin
                if (old_a_hit) begin
                    a_rdy_d = 1'b1;
                    a_d     = bus_data;
                end
                if (old_b_hit) begin
                    b_rdy_d = 1'b1;
                    b_d     = bus_data;
                end
                if (a_rdy_d && b_rdy_d) state_d = SLOT_READY;
            end
            SLOT_READY: begin
                if (grant) state_d = SLOT_FREE;
            end
            default: state_d = SLOT_FREE;
        endcase
        if (flush) state_d = SLOT_FREE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SLOT_FREE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q    <= '0;
            dst_q   <= '0;
            a_rdy_q <= 1'b0;
            a_q     <= '0;
            a_tag_q <= '0;
            b_rdy_q <= 1'b0;
            b_q     <= '0;
            b_tag_q <= '0;
        end else begin
            op_q    <= op_d;
            dst_q   <= dst_d;
            a_rdy_q <= a_rdy_d;
            a_q     <= a_d;
            a_tag_q <= a_tag_d;
            b_rdy_q <= b_rdy_d;
            b_q     <= b_d;
            b_tag_q <= b_tag_d;
        end
    end

    always_comb begin
        out_free  = (state_q == SLOT_FREE);
        out_ready = (state_q == SLOT_READY);
        out_op    = op_q;
        out_dst   = dst_q;
        out_a     = a_q;
        out_b     = b_q;
    end
endmodule

// File: rtl/rs_alloc.sv
module rs_alloc #(
    parameter int NUM_SLOTS = 4
) (
    input  logic [NUM_SLOTS-1:0] free_vec,
    output logic [NUM_SLOTS-1:0] pick_oh
);
    always_comb begin
        logic found;
        found   = 1'b0;
        pick_oh = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (free_vec[i] && !found) begin
                pick_oh[i] = 1'b1;
                found      = 1'b1;
            end
        end
    end
endmodule

// File: rtl/rs_age_pick.sv
module rs_age_pick #(
    parameter int NUM_SLOTS = 4,
    parameter int TAG_W     = 4
) (
    input  logic [NUM_SLOTS-1:0] ready_vec,
    input  logic [TAG_W-1:0]     dst_vec [NUM_SLOTS],
    input  logic [TAG_W-1:0]     head,
    output logic [NUM_SLOTS-1:0] pick_oh
);
    always_comb begin
        logic             found;
        logic [TAG_W-1:0] best_age;
        logic [TAG_W-1:0] age;
        found    = 1'b0;
        best_age = '0;
        pick_oh  = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            age = dst_vec[i] - head;
            if (ready_vec[i] && (!found || age < best_age)) begin
                pick_oh    = '0;
                pick_oh[i] = 1'b1;
                best_age   = age;
                found      = 1'b1;
            end
        end
    end
endmodule

// File: rtl/rs_pool.sv
module rs_pool #(
    parameter int NUM_SLOTS = 4,
    parameter int OP_W      = 4,
    parameter int TAG_W     = 4,
    parameter int DATA_W    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic [TAG_W-1:0]  rob_head,
    input  logic              rob_avail,
    input  logic              iss_valid,
    output logic              iss_ready,
    input  logic [OP_W-1:0]   iss_op,
    input  logic [TAG_W-1:0]  iss_dst,
    input  logic              iss_a_rdy,
    input  logic [DATA_W-1:0] iss_a_val,
    input  logic [TAG_W-1:0]  iss_a_tag,
    input  logic              iss_b_rdy,
    input  logic [DATA_W-1:0] iss_b_val,
    input  logic [TAG_W-1:0]  iss_b_tag,
    input  logic              bus_valid,
    input  logic [TAG_W-1:0]  bus_tag,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              fu_ready,
    output logic              disp_valid,
    output logic [OP_W-1:0]   disp_op,
    output logic [TAG_W-1:0]  disp_dst,
    output logic [DATA_W-1:0] disp_a,
    output logic [DATA_W-1:0] disp_b
);
    logic [NUM_SLOTS-1:0] slot_free, slot_ready, slot_alloc, slot_pick;
    logic [NUM_SLOTS-1:0] slot_load, slot_grant;
    logic [OP_W-1:0]      slot_op  [NUM_SLOTS];
    logic [TAG_W-1:0]     slot_dst [NUM_SLOTS];
    logic [DATA_W-1:0]    slot_a   [NUM_SLOTS];
    logic [DATA_W-1:0]    slot_b   [NUM_SLOTS];
    logic                 accept;

    assign iss_ready  = |slot_free;
    assign accept     = iss_valid && rob_avail && iss_ready && !flush;
    assign slot_load  = accept ? slot_alloc : '0;
    assign slot_grant = fu_ready ? slot_pick : '0;
    assign disp_valid = |slot_ready;

    rs_alloc #(.NUM_SLOTS(NUM_SLOTS)) u_alloc (
        .free_vec (slot_free),
        .pick_oh  (slot_alloc)
    );

    rs_age_pick #(.NUM_SLOTS(NUM_SLOTS), .TAG_W(TAG_W)) u_pick (
        .ready_vec (slot_ready),
        .dst_vec   (slot_dst),
        .head      (rob_head),
        .pick_oh   (slot_pick)
    );

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        rs_slot #(.OP_W(OP_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .flush     (flush),
            .load      (slot_load[g]),
            .grant     (slot_grant[g]),
            .in_op     (iss_op),
            .in_dst    (iss_dst),
            .in_a_rdy  (iss_a_rdy),
            .in_a_val  (iss_a_val),
            .in_a_tag  (iss_a_tag),
            .in_b_rdy  (iss_b_rdy),
            .in_b_val  (iss_b_val),
            .in_b_tag  (iss_b_tag),
            .bus_valid (bus_valid),
            .bus_tag   (bus_tag),
            .bus_data  (bus_data),
            .out_free  (slot_free[g]),
            .out_ready (slot_ready[g]),
            .out_op    (slot_op[g]),
            .out_dst   (slot_dst[g]),
            .out_a     (slot_a[g]),
            .out_b     (slot_b[g])
        );
    end

    always_comb begin
        disp_op  = '0;
        disp_dst = '0;
        disp_a   = '0;
        disp_b   = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (slot_pick[i]) begin
                disp_op  = disp_op  | slot_op[i];
                disp_dst = disp_dst | slot_dst[i];
                disp_a   = disp_a   | slot_a[i];
                disp_b   = disp_b   | slot_b[i];
            end
        end
    end
endmodule

// File: rtl/rs_pool_chk.sv
module rs_pool_chk #(
    parameter int NUM_SLOTS = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 flush,
    input logic                 iss_valid,
    input logic                 rob_avail,
    input logic                 disp_valid,
    input logic                 fu_ready,
    input logic [NUM_SLOTS-1:0] slot_free,
    input logic [NUM_SLOTS-1:0] slot_ready,
    input logic [NUM_SLOTS-1:0] slot_pick
);
    AST_SINGLE_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(slot_pick)); // R7

    AST_OFFER_IS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_pick & ~slot_ready) == '0); // R4

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (&slot_free)); // R9

    AST_NO_ISSUE_NO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        !(iss_valid && rob_avail) |=> $countones(slot_free) >= $past($countones(slot_free))); // R1

    AST_DISPATCH_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && fu_ready && !flush) |=> ((slot_free & $past(slot_pick)) == $past(slot_pick))); // R6
endmodule

bind rs_pool rs_pool_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .iss_valid  (iss_valid),
    .rob_avail  (rob_avail),
    .disp_valid (disp_valid),
    .fu_ready   (fu_ready),
    .slot_free  (slot_free),
    .slot_ready (slot_ready),
    .slot_pick  (slot_pick)
);

// File: tb/tb_rs_pool.sv
module tb_rs_pool;
    localparam int OP_W = 4, TAG_W = 4, DATA_W = 16;

    logic              clk = 1'b0;
    logic              rst_n, flush, rob_avail, iss_valid, iss_ready;
    logic [TAG_W-1:0]  rob_head;
    logic [OP_W-1:0]   iss_op;
    logic [TAG_W-1:0]  iss_dst, iss_a_tag, iss_b_tag, bus_tag, disp_dst;
    logic              iss_a_rdy, iss_b_rdy, bus_valid, fu_ready, disp_valid;
    logic [DATA_W-1:0] iss_a_val, iss_b_val, bus_data, disp_a, disp_b;
    logic [OP_W-1:0]   disp_op;

    int n_run = 0, n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    rs_pool #(.NUM_SLOTS(4), .OP_W(OP_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) dut (.*);

    // op, dst, a, b
    localparam logic [39:0] VEC [0:3] = '{
        {4'h1, 4'h0, 16'h1234, 16'h00FF},
        {4'h7, 4'h5, 16'hFFFF, 16'h0000},
        {4'hA, 4'hF, 16'h0001, 16'h8000},
        {4'h3, 4'h9, 16'hBEEF, 16'hCAFE}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        iss_valid = 0; bus_valid = 0; fu_ready = 0; flush = 0;
    endtask

    task automatic issue(input logic [3:0] op, input logic [3:0] dst,
                         input logic ar, input logic [15:0] av, input logic [3:0] at,
                         input logic br, input logic [15:0] bv, input logic [3:0] bt);
        iss_valid = 1; iss_op = op; iss_dst = dst;
        iss_a_rdy = ar; iss_a_val = av; iss_a_tag = at;
        iss_b_rdy = br; iss_b_val = bv; iss_b_tag = bt;
    endtask

    task automatic bcast(input logic [3:0] t, input logic [15:0] d);
        bus_valid = 1; bus_tag = t; bus_data = d;
    endtask

    task automatic tick();
        @(negedge clk);
        idle();
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 0; rob_avail = 1; rob_head = 0; idle();
        iss_op = 0; iss_dst = 0; iss_a_rdy = 0; iss_b_rdy = 0;
        iss_a_val = 0; iss_b_val = 0; iss_a_tag = 0; iss_b_tag = 0;
        bus_tag = 0; bus_data = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        chk("R10 iss_ready", iss_ready, 1);
        chk("R10 disp_valid", disp_valid, 0);

        // Table: ready operands pass through, then release on dispatch
        for (int i = 0; i < 4; i++) begin
            issue(VEC[i][39:36], VEC[i][35:32], 1, VEC[i][31:16], 0, 1, VEC[i][15:0], 0);
            tick();
            chk("R2 valid", disp_valid, 1);
            chk("R2 op", disp_op, VEC[i][39:36]);
            chk("R2 dst", disp_dst, VEC[i][35:32]);
            chk("R2 a", disp_a, VEC[i][31:16]);
            chk("R2 b", disp_b, VEC[i][15:0]);
            fu_ready = 1;
            tick();
            chk("R6 released", disp_valid, 0);
        end

        // Fill with pending instructions
        issue(1, 1, 0, 0, 9, 1, 16'h0005, 0);  tick();
        issue(2, 2, 1, 16'h0007, 0, 0, 0, 9);  tick();
        issue(3, 3, 0, 0, 10, 1, 16'h0001, 0); tick();
        issue(4, 4, 0, 0, 11, 0, 0, 11);       tick();
        chk("R1 full", iss_ready, 0);
        chk("R4 none ready", disp_valid, 0);
        issue(5, 8, 1, 16'h1111, 0, 1, 16'h2222, 0); tick();  // rejected: full
        chk("R1 rejected when full", disp_valid, 0);

        // One broadcast wakes two slots; oldest first
        bcast(9, 16'h0055); tick();
        chk("R5 wake", disp_valid, 1);
        chk("R7 oldest dst", disp_dst, 1);
        chk("R3 captured a", disp_a, 16'h0055);
        chk("R2 kept b", disp_b, 16'h0005);
        fu_ready = 1; tick();
        chk("R5 second dst", disp_dst, 2);
        chk("R5 second b", disp_b, 16'h0055);
        fu_ready = 1; tick();
        chk("R1 full issue discarded", disp_valid, 0);

        // Both sources on the same tag, then age ordering with wrap
        bcast(11, 16'h0033); tick();
        chk("R3 both sources", disp_dst, 4);
        chk("R3 both a", disp_a, 16'h0033);
        chk("R3 both b", disp_b, 16'h0033);
        bcast(10, 16'h0044); tick();
        chk("R7 head0 picks dst3", disp_dst, 3);
        rob_head = 4; #1;
        chk("R7 head4 picks dst4", disp_dst, 4);
        fu_ready = 1; tick();
        chk("R7 next dst3", disp_dst, 3);
        chk("R3 captured c", disp_a, 16'h0044);
        chk("R6 hold", disp_valid, 1);
        #1; chk("R6 hold stable", disp_dst, 3);
        fu_ready = 1; tick();
        chk("R6 empty", disp_valid, 0);
        rob_head = 0;

        // Same-cycle issue and broadcast
        issue(6, 5, 0, 0, 12, 1, 16'h0009, 0); bcast(12, 16'h0077); tick();
        chk("R8 same-cycle valid", disp_valid, 1);
        chk("R8 same-cycle a", disp_a, 16'h0077);
        fu_ready = 1; tick();
        issue(6, 6, 0, 0, 13, 1, 16'h0009, 0); bcast(14, 16'h0066); tick();
        chk("R3 mismatch no capture", disp_valid, 0);

        // Flush with concurrent issue
        issue(7, 7, 1, 16'h0001, 0, 1, 16'h0002, 0); flush = 1; tick();
        chk("R9 no dispatch", disp_valid, 0);
        chk("R9 all free", iss_ready, 1);
        bcast(13, 16'h0099); tick();
        chk("R9 flushed slot stays gone", disp_valid, 0);

        // No reorder-buffer entry
        rob_avail = 0; issue(8, 8, 1, 16'h0003, 0, 1, 16'h0004, 0); tick();
        chk("R1 rob unavailable", disp_valid, 0);
        rob_avail = 1;

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule